// File: doc/BRIEF.md
# Radio transceiver state controller

This block is the control state machine of a low-power packet radio. It steps the receiver through power-off, regulator start-up, synthesizer-on, listen, busy-receive and a listen state that stops the output clock. A register write delivers a state command, and the sleep pin drives the clockless state. The analog regulator, the synthesizer, the demodulator, the checksum unit and the frame buffer sit outside the block. Each of them reaches it through a plain indication or a byte stream.

Status shows the listen code as soon as a receive command is taken, even before the synthesizer has locked. Sync-header acceptance stays blocked until lock. Payload bytes pass from the demodulator to the frame buffer only while busy-receive lasts.

The payload path is valid/ready. A byte moves on a clock edge where `rx_valid` and `rx_ready` are both high. `rx_ready` follows `fb_ready` during busy-receive and is low in every other state. Because of this, back-pressure from the frame buffer stalls the demodulator, and nothing is dropped. `fb_valid` and `fb_data` follow the demodulator stream straight through, with no extra delay.

Interrupt outputs are one-cycle pulses, each gated by its own mask bit. They also collect into a sticky register that a read strobe clears.

Top module: `radio_state_ctrl`

## Requirements
- R1: After reset, `status` is 5'h08 (off), `reg_en` and `pll_en` are 0 when `reg_hold_on` is 0, `clkm_en` is 1, and `irq_status` is 0.
- R2: A command 5'h09 in off moves to start-up (status 5'h1F) with `reg_en` high and `pll_en` low. Start-up holds until `reg_settled`, then enters synthesizer-on (5'h09) with `pll_en` high. If `reg_hold_on` and `reg_settled` are both high, the command goes straight to 5'h09. `reg_hold_on` alone drives `reg_en` high in off.
- R3: A rising `pll_locked` while `pll_en` is high gives a one-cycle pulse on `irq_pulse[0]` one cycle later, provided `irq_mask[0]` is set.
- R4: A command 5'h06 in synthesizer-on shows status 5'h06 (listen) the next cycle, whatever the state of `pll_locked`.
- R5: In listen, `shr_det` moves to busy-receive (5'h01) only while `pll_locked` is high. Otherwise it is ignored.
- R6: In busy-receive, `phr_valid` with a non-zero `phr_len` pulses `irq_pulse[1]` one cycle later if `irq_mask[1]` is set. A zero length gives no pulse.
- R7: In busy-receive, every accepted byte reaches the frame buffer in order, with `rx_ready` equal to `fb_ready`. Outside busy-receive, `rx_ready` and `fb_valid` are 0.
- R8: Accepting the byte marked `rx_last` returns the block to listen. One cycle later it pulses `irq_pulse[2]` (if `irq_mask[2]` is set) and loads `crc_valid` from `fcs_ok`.
- R9: Listen never exits by itself. A code other than 5'h08, 5'h09 or 5'h06, a command that does not apply in the current state, and any command during start-up or busy-receive all leave the state unchanged.
- R10: A rising `slp_tr` in listen enters 5'h1C. `clkm_en` drops 35 clock edges after the edge that sampled the rise. A low `slp_tr` returns the block to listen with `clkm_en` high.
- R11: Each `irq_status` bit is set with its pulse and holds until `irq_rd`, which clears it the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | State command strobe |
| cmd_code | input | 5 | State command: 5'h08 off, 5'h09 synthesizer-on, 5'h06 listen |
| reg_hold_on | input | 1 | Register bit keeping the regulator on while off |
| slp_tr | input | 1 | Sleep pin |
| reg_settled | input | 1 | Regulator settled |
| pll_locked | input | 1 | Synthesizer lock |
| shr_det | input | 1 | Sync header detected |
| phr_valid | input | 1 | Header length field valid |
| phr_len | input | PHR_W | Header length field |
| rx_valid | input | 1 | Payload byte valid |
| rx_ready | output | 1 | Payload byte accepted |
| rx_data | input | DATA_W | Payload byte |
| rx_last | input | 1 | Last payload byte |
| fcs_ok | input | 1 | Frame checksum result |
| fb_valid | output | 1 | Frame buffer write valid |
| fb_ready | input | 1 | Frame buffer can accept |
| fb_data | output | DATA_W | Frame buffer write data |
| irq_mask | input | 3 | Interrupt enables: bit0 lock, bit1 receive start, bit2 transfer end |
| irq_rd | input | 1 | Sticky status read strobe |
| status | output | 5 | State code |
| reg_en | output | 1 | Regulator enable |
| pll_en | output | 1 | Synthesizer enable |
| irq_pulse | output | 3 | Interrupt pulses |
| irq_status | output | 3 | Sticky interrupt status |
| crc_valid | output | 1 | Stored checksum result |
| clkm_en | output | 1 | Output clock enable |

## Verification
The assertions assume that the demodulator keeps `rx_data` and `rx_last` stable while a byte waits for `rx_ready`. They also assume that `reg_settled` is only high when the regulator has really started. The bench changes every input half a period away from the active edge and holds a stalled byte until it is taken. It raises `reg_settled` only after start-up has been entered, or with the hold bit set. It drops `pll_locked` and `reg_settled` whenever it powers the block down, so a later lock is always a fresh rising edge.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  typedef enum logic [4:0] {
    ST_OFF    = 5'h08,
    ST_REG    = 5'h1F,
    ST_PLL    = 5'h09,
    ST_LISTEN = 5'h06,
    ST_BUSY   = 5'h01,
    ST_NOCLK  = 5'h1C
  } rsc_state_e;

  localparam logic [4:0] CMD_GO_OFF = 5'h08;
  localparam logic [4:0] CMD_GO_PLL = 5'h09;
  localparam logic [4:0] CMD_GO_RX  = 5'h06;

  localparam int IRQ_W       = 3;
  localparam int IRQ_LOCK    = 0;
  localparam int IRQ_RXSTART = 1;
  localparam int IRQ_END     = 2;
endpackage

// File: rtl/rsc_power.sv
module rsc_power
  import rsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rsc_state_e state,
  input  logic       reg_hold_on,
  input  logic       reg_settled,
  input  logic       pll_locked,
  output logic       reg_en,
  output logic       pll_en,
  output logic       lock_evt
);
  logic lock_q;

  assign reg_en = reg_hold_on || (state != ST_OFF);
  assign pll_en = (state == ST_PLL) || (state == ST_LISTEN) ||
                  (state == ST_BUSY) || (state == ST_NOCLK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= pll_locked;
  end

  assign lock_evt = pll_en && pll_locked && !lock_q;

  // R2: synthesizer only starts after the regulator reported settled
  p_pll_after_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> $past(reg_settled));

  // R2: synthesizer never runs without the regulator
  p_pll_needs_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pll_en |-> reg_en);
endmodule

// File: rtl/rsc_irq.sv
module rsc_irq #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] mask,
  input  logic         rd,
  output logic [W-1:0] pulse,
  output logic [W-1:0] sticky
);
  logic [W-1:0] hit;
  assign hit = evt & mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse  <= '0;
      sticky <= '0;
    end else begin
      pulse  <= hit;
      sticky <= (rd ? '0 : sticky) | hit;
    end
  end

  // R3: a pulse only appears on an enabled line
  p_pulse_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse & ~$past(mask)) == '0);

  // R11: without a read, set bits stay set
  p_sticky_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> ((sticky & $past(sticky)) == $past(sticky)));

  // R11: every pulse is mirrored in the sticky register
  p_sticky_catch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse & ~sticky) == '0);
endmodule

// File: rtl/rsc_clkgate.sv
module rsc_clkgate #(
  parameter int DLY = 35
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  input  logic in_noclk,
  output logic clkm_en
);
  localparam int CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DLY);

  logic [CW-1:0] cnt;
  logic          off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      off <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      off <= 1'b0;
    end else if (start) begin
      cnt <= CW'(1);
      off <= 1'b0;
    end else if (cnt == LIMIT) begin
      off <= 1'b1;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign clkm_en = !off;

  // R10: the output clock is only ever stopped in the clockless state
  p_clk_off_noclk_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !clkm_en |-> in_noclk);
endmodule

// File: rtl/radio_state_ctrl.sv
module radio_state_ctrl
  import rsc_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PHR_W   = 7,
  parameter int CLK_DLY = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [4:0]        cmd_code,
  input  logic              reg_hold_on,
  input  logic              slp_tr,
  input  logic              reg_settled,
  input  logic              pll_locked,
  input  logic              shr_det,
  input  logic              phr_valid,
  input  logic [PHR_W-1:0]  phr_len,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_last,
  input  logic              fcs_ok,
  output logic              fb_valid,
  input  logic              fb_ready,
  output logic [DATA_W-1:0] fb_data,
  input  logic [IRQ_W-1:0]  irq_mask,
  input  logic              irq_rd,
  output logic [4:0]        status,
  output logic              reg_en,
  output logic              pll_en,
  output logic [IRQ_W-1:0]  irq_pulse,
  output logic [IRQ_W-1:0]  irq_status,
  output logic              crc_valid,
  output logic              clkm_en
);
  rsc_state_e       state, state_d;
  logic             slp_q;
  logic             slp_rise;
  logic             busy;
  logic             rx_fire;
  logic             lock_evt;
  logic [IRQ_W-1:0] evt;

  assign busy     = (state == ST_BUSY);
  assign slp_rise = slp_tr && !slp_q;

  // payload stream: pass-through during busy-receive only
  assign rx_ready = busy && fb_ready;
  assign fb_valid = busy && rx_valid;
  assign fb_data  = rx_data;
  assign rx_fire  = rx_valid && rx_ready;

  always_comb begin
    state_d = state;
    case (state)
      ST_OFF:
        if (cmd_valid && cmd_code == CMD_GO_PLL)
          state_d = (reg_hold_on && reg_settled) ? ST_PLL : ST_REG;
      ST_REG:
        if (reg_settled) state_d = ST_PLL;
      ST_PLL:
        if (cmd_valid && cmd_code == CMD_GO_RX)       state_d = ST_LISTEN;
        else if (cmd_valid && cmd_code == CMD_GO_OFF) state_d = ST_OFF;
      ST_LISTEN:
        if (cmd_valid && cmd_code == CMD_GO_PLL)      state_d = ST_PLL;
        else if (cmd_valid && cmd_code == CMD_GO_OFF) state_d = ST_OFF;
        else if (slp_rise)                            state_d = ST_NOCLK;
        else if (shr_det && pll_locked)               state_d = ST_BUSY;
      ST_BUSY:
        if (rx_fire && rx_last) state_d = ST_LISTEN;
      ST_NOCLK:
        if (!slp_tr) state_d = ST_LISTEN;
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_OFF;
      slp_q     <= 1'b0;
      crc_valid <= 1'b0;
    end else begin
      state <= state_d;
      slp_q <= slp_tr;
      if (rx_fire && rx_last) crc_valid <= fcs_ok;
    end
  end

  assign status = state;

  always_comb begin
    evt              = '0;
    evt[IRQ_LOCK]    = lock_evt;
    evt[IRQ_RXSTART] = busy && phr_valid && (phr_len != '0);
    evt[IRQ_END]     = rx_fire && rx_last;
  end

  rsc_power u_power (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .reg_hold_on(reg_hold_on),
    .reg_settled(reg_settled),
    .pll_locked (pll_locked),
    .reg_en     (reg_en),
    .pll_en     (pll_en),
    .lock_evt   (lock_evt)
  );

  rsc_irq #(.W(IRQ_W)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt),
    .mask  (irq_mask),
    .rd    (irq_rd),
    .pulse (irq_pulse),
    .sticky(irq_status)
  );

  rsc_clkgate #(.DLY(CLK_DLY)) u_clkgate (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   ((state == ST_LISTEN) && (state_d == ST_NOCLK)),
    .run     (state_d == ST_NOCLK),
    .in_noclk(state == ST_NOCLK),
    .clkm_en (clkm_en)
  );

  // R5: busy-receive is only reached while the synthesizer is locked
  p_sync_needs_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_BUSY && $past(status) != ST_BUSY) |-> $past(pll_locked));

  // R8: the final accepted byte brings the block back to listen
  p_end_to_listen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready && rx_last) |=> (status == ST_LISTEN));

  // R9: listen is held when nothing asks to leave it
  p_listen_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status == ST_LISTEN && !cmd_valid && !shr_det && !slp_tr)
      |=> (status == ST_LISTEN));

  // R7: frame buffer writes occur only during busy-receive
  p_fb_busy_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_valid && fb_ready) |-> (status == ST_BUSY));
endmodule

// File: tb/radio_state_ctrl_tb.sv
module radio_state_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid;
  logic [4:0] cmd_code;
  logic       reg_hold_on, slp_tr, reg_settled, pll_locked, shr_det;
  logic       phr_valid;
  logic [6:0] phr_len;
  logic       rx_valid, rx_ready, rx_last, fcs_ok;
  logic [7:0] rx_data, fb_data;
  logic       fb_valid, fb_ready;
  logic [2:0] irq_mask, irq_pulse, irq_status;
  logic       irq_rd;
  logic [4:0] status;
  logic       reg_en, pll_en, crc_valid, clkm_en;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  bit bp_on = 0;
  logic [7:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  radio_state_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .reg_hold_on(reg_hold_on), .slp_tr(slp_tr), .reg_settled(reg_settled),
    .pll_locked(pll_locked), .shr_det(shr_det), .phr_valid(phr_valid),
    .phr_len(phr_len), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_last(rx_last), .fcs_ok(fcs_ok),
    .fb_valid(fb_valid), .fb_ready(fb_ready), .fb_data(fb_data),
    .irq_mask(irq_mask), .irq_rd(irq_rd), .status(status),
    .reg_en(reg_en), .pll_en(pll_en), .irq_pulse(irq_pulse),
    .irq_status(irq_status), .crc_valid(crc_valid), .clkm_en(clkm_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd(input logic [4:0] c);
    cmd_valid = 1'b1;
    cmd_code  = c;
    tick(1);
    cmd_valid = 1'b0;
  endtask

  // driver: pushes the expected byte, holds it until accepted
  task automatic send_byte(input logic [7:0] d, input logic l);
    @(negedge clk);
    exp_q.push_back(d);
    rx_valid = 1'b1;
    rx_data  = d;
    rx_last  = l;
    forever begin
      #1;
      if (rx_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  // back-pressure pattern from the frame buffer
  always @(negedge clk) if (bp_on) fb_ready = ~fb_ready;

  // monitor: a transfer will happen at the next edge, compare with queue (R7)
  always @(negedge clk) begin
    #2;
    if (rst_n && fb_valid && fb_ready) begin
      if (exp_q.size() == 0) chk("R7 unexpected write", {24'h0, fb_data}, 32'hFFFF);
      else chk("R7 frame byte", {24'h0, fb_data}, {24'h0, exp_q.pop_front()});
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cmd_valid = 0; cmd_code = 0; reg_hold_on = 0; slp_tr = 0;
    reg_settled = 0; pll_locked = 0; shr_det = 0; phr_valid = 0; phr_len = 0;
    rx_valid = 0; rx_data = 0; rx_last = 0; fcs_ok = 0; fb_ready = 1;
    irq_mask = 3'b111; irq_rd = 0;
    tick(3);
    rst_n = 1;
    tick(1);
    chk("R1 status", status, 5'h08);
    chk("R1 reg_en", reg_en, 0);
    chk("R1 pll_en", pll_en, 0);
    chk("R1 clkm_en", clkm_en, 1);
    chk("R1 irq_status", irq_status, 0);

    cmd(5'h06);
    chk("R9 rx cmd in off ignored", status, 5'h08);

    cmd(5'h09);
    chk("R2 startup status", status, 5'h1F);
    chk("R2 reg_en on", reg_en, 1);
    chk("R2 pll_en waits", pll_en, 0);
    cmd(5'h08);
    tick(2);
    chk("R9 command during startup ignored", status, 5'h1F);
    chk("R2 pll_en still waits", pll_en, 0);
    reg_settled = 1;
    tick(1);
    chk("R2 pll-on status", status, 5'h09);
    chk("R2 pll_en on", pll_en, 1);

    cmd(5'h06);
    chk("R4 listen code before lock", status, 5'h06);

    shr_det = 1;
    tick(2);
    shr_det = 0;
    chk("R5 sync ignored without lock", status, 5'h06);

    rx_valid = 1; rx_data = 8'hAA;
    #1;
    chk("R7 no ready in listen", rx_ready, 0);
    chk("R7 no write in listen", fb_valid, 0);
    tick(1);
    rx_valid = 0;

    tick(40);
    chk("R9 listen holds by itself", status, 5'h06);
    cmd(5'h15);
    chk("R9 unknown code ignored", status, 5'h06);

    pll_locked = 1;
    tick(1);
    chk("R3 lock pulse", irq_pulse[0], 1);
    tick(1);
    chk("R3 lock pulse single", irq_pulse[0], 0);
    chk("R11 sticky lock bit", irq_status, 3'b001);
    irq_rd = 1;
    tick(1);
    irq_rd = 0;
    chk("R11 cleared by read", irq_status, 0);

    shr_det = 1;
    tick(1);
    shr_det = 0;
    chk("R5 sync accepted after lock", status, 5'h01);
    cmd(5'h08);
    chk("R9 command in busy ignored", status, 5'h01);

    phr_valid = 1; phr_len = 0;
    tick(1);
    phr_valid = 0;
    chk("R6 zero length no pulse", irq_pulse[1], 0);
    phr_valid = 1; phr_len = 7'd20;
    tick(1);
    phr_valid = 0;
    chk("R6 non-zero length pulse", irq_pulse[1], 1);

    fcs_ok = 1;
    bp_on = 1;
    for (int i = 0; i < 5; i++) send_byte(8'h30 + 8'(i), i == 4);
    @(negedge clk);
    rx_valid = 0; rx_last = 0;
    bp_on = 0;
    fb_ready = 1;
    chk("R8 back to listen", status, 5'h06);
    chk("R8 end pulse", irq_pulse[2], 1);
    chk("R8 crc stored good", crc_valid, 1);
    chk("R7 all bytes written", exp_q.size(), 0);

    irq_mask = 3'b101;
    fcs_ok = 0;
    shr_det = 1;
    tick(1);
    shr_det = 0;
    phr_valid = 1; phr_len = 7'd9;
    tick(1);
    phr_valid = 0;
    chk("R6 masked start no pulse", irq_pulse[1], 0);
    send_byte(8'h5C, 0);
    send_byte(8'hC5, 1);
    @(negedge clk);
    rx_valid = 0; rx_last = 0;
    chk("R8 crc stored bad", crc_valid, 0);
    chk("R8 end pulse second frame", irq_pulse[2], 1);
    chk("R7 second frame written", exp_q.size(), 0);
    irq_mask = 3'b111;

    slp_tr = 1;
    tick(1);
    chk("R10 clockless status", status, 5'h1C);
    begin
      bit early_off = 0;
      for (int j = 1; j <= 34; j++) begin
        tick(1);
        if (!clkm_en) early_off = 1;
      end
      chk("R10 clock kept for 34 edges", early_off, 0);
    end
    tick(1);
    chk("R10 clock off at edge 35", clkm_en, 0);
    slp_tr = 0;
    tick(1);
    chk("R10 back to listen", status, 5'h06);
    chk("R10 clock restored", clkm_en, 1);

    cmd(5'h08);
    pll_locked = 0;
    reg_settled = 0;
    chk("R2 off status", status, 5'h08);
    chk("R2 regulator off", reg_en, 0);
    chk("R2 synthesizer off", pll_en, 0);
    reg_hold_on = 1;
    tick(1);
    chk("R2 hold bit keeps regulator", reg_en, 1);
    reg_settled = 1;
    cmd(5'h09);
    chk("R2 direct to pll-on", status, 5'h09);
    cmd(5'h15);
    chk("R9 unknown code in pll-on", status, 5'h09);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule